// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Controller

This block sits beside a small microcontroller core. It gathers five request sources: two timer overflows, one serial event, and two active-low external pins. It masks them with an enable byte, latches the ones that must persist, and picks a single winner by fixed priority. It then presents the winner to the core as a request strobe with a 16-bit vector address.

The core takes the vector only at an instruction boundary. It later reports the end of the service routine with a return strobe. While one request is in service, every other request is held back.

Each external pin can be sensed in one of two ways, chosen by a mode byte. In level mode, the pin requests service for as long as it reads low. In edge mode, a falling edge leaves a pending flag that hardware clears when the vector is taken. Timer flags are also cleared on acceptance. The serial event is the OR of a transmit-done flag and a receive-done flag, and only software clears those two flags.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the enable byte is 0x00 and both pins are in level mode, so `req_o` stays low whatever the sources do until software writes the enable byte.
- R2: A source can raise `req_o` only when enable bit 7 (global) and its own enable bit are both 1. The bit map is: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial.
- R3: Among the eligible sources, the lowest enable-bit index wins. `vec_o` is 0x0003 + 8*index: 0x0003, 0x000B, 0x0013, 0x001B or 0x0023.
- R4: In level mode a pin held low requests service. If the pin is still low when `reti_i` is strobed, a new request appears in the cycle after the return. Once the pin reads high, the request is withdrawn.
- R5: In edge mode a high-to-low change seen on two successive clock samples sets a pending flag. The flag holds after the pin returns high and is cleared when its vector is accepted. A pin that stays low does not raise a request again.
- R6: `req_o` and `vec_o` stay asserted, with no time limit, until the core strobes `boundary_i` while `req_o` is high. That cycle is the acceptance.
- R7: From acceptance until `reti_i`, `req_o` stays low. New events stay latched during that time and are presented after the return.
- R8: A one-cycle `tmr_ovf_i[k]` pulse sets the flag of timer k. Accepting the timer's vector clears that flag.
- R9: The serial source is the OR of two flags. `ser_tx_done_i` sets the transmit flag and `ser_rx_done_i` sets the receive flag. Accepting the vector does not clear them. `ser_clr_i[0]` clears the transmit flag and `ser_clr_i[1]` clears the receive flag.
- R10: Mode byte bit 0 selects edge sensing for external 0 and bit 2 does so for external 1. All other mode bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Target of the write: 0 selects the enable byte, 1 selects the mode byte |
| cfg_wdata_i | input | 8 | Write data |
| tmr_ovf_i | input | 2 | Timer overflow pulses, one per timer |
| ser_tx_done_i | input | 1 | Transmit-done pulse |
| ser_rx_done_i | input | 1 | Receive-done pulse |
| ser_clr_i | input | 2 | Software clear of the serial flags: bit 0 transmit, bit 1 receive |
| ext_n_i | input | 2 | External request pins, active low |
| boundary_i | input | 1 | Core is at an instruction boundary |
| reti_i | input | 1 | Core is returning from the service routine |
| req_o | output | 1 | Interrupt request to the core |
| vec_o | output | 16 | Vector address of the winning source; zero when there is no request |

## Verification
A corrupted pending or in-service bit shows up at the ports in the first cycle after it goes wrong. One symptom is a request that should not exist, or a missing one. Another is a vector that names the wrong source. A third is a source that returns after a `reti_i` it should have survived, or fails to return. The sweep covers every pairing of enable mask and active-source set and compares the winning vector arithmetically. Directed sequences cover each acceptance and return path for level, edge, timer and serial sources, which exposes flags that are cleared on the wrong event.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int NUM_EXT = 2;

  typedef enum logic [2:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;
endpackage

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over a simultaneous clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/irq_ext_sense.sv
module irq_ext_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic active_o
);
  logic smp_q, prev_q, pend_q, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      smp_q  <= pin_n_i;
      prev_q <= smp_q;
    end
  end

  assign fall = prev_q & ~smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pend_q <= 1'b0;
    else if (!edge_mode_i) pend_q <= 1'b0;
    else if (fall)         pend_q <= 1'b1;
    else if (clr_i)        pend_q <= 1'b0;
  end

  assign active_o = edge_mode_i ? pend_q : ~smp_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N     = 5,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     grant_o
);
  // lowest index has highest priority
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int CFG_W      = 8,
  parameter int GEN_BIT    = 7,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic [1:0]        tmr_ovf_i,
  input  logic              ser_tx_done_i,
  input  logic              ser_rx_done_i,
  input  logic [1:0]        ser_clr_i,
  input  logic [1:0]        ext_n_i,
  input  logic              boundary_i,
  input  logic              reti_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] vec_o
);
  import irq_pkg::*;

  localparam int NSRC  = NUM_SRC;
  localparam int IDX_W = $clog2(NSRC);

  logic [CFG_W-1:0] en_q, mode_q;
  logic [NSRC-1:0]  src, elig, grant;
  logic [IDX_W-1:0] win_idx;
  logic             any_elig, insvc_q, ack;
  logic             ser_tx_q, ser_rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mode_q <= '0;
    end else if (cfg_we_i) begin
      if (cfg_sel_i) mode_q <= cfg_wdata_i;
      else           en_q   <= cfg_wdata_i;
    end
  end

  // external k sits at source 2k, timer k at source 2k+1
  for (genvar k = 0; k < NUM_EXT; k++) begin : g_pair
    irq_ext_sense u_ext (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_n_i    (ext_n_i[k]),
      .edge_mode_i(mode_q[2*k]),
      .clr_i      (ack & grant[2*k]),
      .active_o   (src[2*k])
    );
    irq_flag u_tmr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (tmr_ovf_i[k]),
      .clr_i (ack & grant[2*k+1]),
      .flag_o(src[2*k+1])
    );
  end

  irq_flag u_ser_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ser_tx_done_i),
    .clr_i (ser_clr_i[0]),
    .flag_o(ser_tx_q)
  );

  irq_flag u_ser_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ser_rx_done_i),
    .clr_i (ser_clr_i[1]),
    .flag_o(ser_rx_q)
  );

  assign src[SRC_SER] = ser_tx_q | ser_rx_q;
  assign elig = src & en_q[NSRC-1:0] & {NSRC{en_q[GEN_BIT]}};

  irq_prio #(.N(NSRC), .IDX_W(IDX_W)) u_prio (
    .req_i  (elig),
    .any_o  (any_elig),
    .idx_o  (win_idx),
    .grant_o(grant)
  );

  assign req_o = any_elig & ~insvc_q;
  assign ack   = req_o & boundary_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     insvc_q <= 1'b0;
    else if (ack)    insvc_q <= 1'b1;
    else if (reti_i) insvc_q <= 1'b0;
  end

  assign vec_o = req_o ? ADDR_W'(VEC_BASE) + ADDR_W'(win_idx) * ADDR_W'(VEC_STRIDE)
                       : '0;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int ADDR_W     = 16,
  parameter int CFG_W      = 8,
  parameter int GEN_BIT    = 7,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int NSRC       = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              cfg_sel_i,
  input logic [CFG_W-1:0]  cfg_wdata_i,
  input logic              boundary_i,
  input logic              reti_i,
  input logic              req_o,
  input logic [ADDR_W-1:0] vec_o,
  input logic [NSRC-1:0]   grant
);
  logic en_written, gen_shadow, in_svc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_written <= 1'b0;
      gen_shadow <= 1'b0;
      in_svc     <= 1'b0;
    end else begin
      if (cfg_we_i && !cfg_sel_i) begin
        en_written <= 1'b1;
        gen_shadow <= cfg_wdata_i[GEN_BIT];
      end
      if (req_o && boundary_i) in_svc <= 1'b1;
      else if (reti_i)         in_svc <= 1'b0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_written |-> !req_o);

  assert_global_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_shadow |-> !req_o);

  assert_vec_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (int'(vec_o) >= VEC_BASE
               && (int'(vec_o) - VEC_BASE) % VEC_STRIDE == 0
               && int'(vec_o) <= VEC_BASE + (NSRC - 1) * VEC_STRIDE));

  assert_single_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  assert_ack_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && boundary_i) |=> !req_o);

  assert_blocked_in_service_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_svc |-> !req_o);
endmodule

bind irq_ctrl irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .CFG_W(CFG_W), .GEN_BIT(GEN_BIT),
  .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE), .NSRC(NSRC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_sel_i  (cfg_sel_i),
  .cfg_wdata_i(cfg_wdata_i),
  .boundary_i (boundary_i),
  .reti_i     (reti_i),
  .req_o      (req_o),
  .vec_o      (vec_o),
  .grant      (grant)
);

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [1:0]  tmr_ovf = '0, ser_clr = '0, ext_n = 2'b11;
  logic        tx_done = 1'b0, rx_done = 1'b0, boundary = 1'b0, reti = 1'b0;
  logic        req;
  logic [15:0] vec;
  int          n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .tmr_ovf_i(tmr_ovf), .ser_tx_done_i(tx_done),
    .ser_rx_done_i(rx_done), .ser_clr_i(ser_clr), .ext_n_i(ext_n),
    .boundary_i(boundary), .reti_i(reti), .req_o(req), .vec_o(vec)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; cfg_we = 1'b0; tmr_ovf = '0; ser_clr = '0; ext_n = 2'b11;
    tx_done = 1'b0; rx_done = 1'b0; boundary = 1'b0; reti = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic take();
    boundary = 1'b1; tick(); boundary = 1'b0;
  endtask

  task automatic ret();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  function automatic int vec_of(input int idx);
    return 3 + 8 * idx;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got 0x0 expected 0x1 (run completion)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 req after reset", int'(req), 0);
    // every source active with the reset enable byte
    ext_n = 2'b00; tmr_ovf = 2'b11; tx_done = 1'b1;
    tick();
    tmr_ovf = '0; tx_done = 1'b0;
    tick();
    chk("R1 sources active, enables at reset value", int'(req), 0);
    wr(1'b0, 8'h1F);
    chk("R2 individual enables without global", int'(req), 0);
    wr(1'b0, 8'h9F);
    chk("R2 global set", int'(req), 1);
    chk("R3 external 0 wins", int'(vec), 3);
    for (int i = 0; i < 4; i++) tick();
    chk("R6 held without boundary", int'(req), 1);
    chk("R6 vector stable", int'(vec), 3);

    // R3 sweep over all enable masks and active-source sets
    for (int m = 0; m < 32; m++) begin
      for (int s = 0; s < 32; s++) begin
        int win;
        do_reset();
        wr(1'b0, 8'(8'h80 | m));
        ext_n   = {~s[2], ~s[0]};
        tmr_ovf = {s[3], s[1]};
        tx_done = s[4];
        tick();
        tmr_ovf = '0; tx_done = 1'b0;
        tick();
        win = -1;
        for (int b = 4; b >= 0; b--) if (((m & s) >> b) & 1) win = b;
        chk("R3 sweep req", int'(req), win >= 0 ? 1 : 0);
        chk("R3 sweep vector", int'(vec), win >= 0 ? vec_of(win) : 0);
      end
    end

    // R4 level re-raise after return
    do_reset();
    wr(1'b0, 8'h81);
    ext_n[0] = 1'b0; tick(); tick();
    chk("R4 level request", int'(req), 1);
    take();
    chk("R7 blocked after acceptance", int'(req), 0);
    ret();
    chk("R4 re-raised while pin low", int'(req), 1);
    chk("R4 re-raised vector", int'(vec), 3);
    ext_n[0] = 1'b1; tick();
    chk("R4 withdrawn when pin high", int'(req), 0);

    // R5 edge mode
    do_reset();
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h81);
    ext_n[0] = 1'b0; tick(); tick();
    chk("R5 edge request", int'(req), 1);
    ext_n[0] = 1'b1; tick(); tick();
    chk("R5 pending after pin high", int'(req), 1);
    take(); ret();
    chk("R5 cleared by acceptance", int'(req), 0);
    ext_n[0] = 1'b0; tick(); tick();
    chk("R5 second edge", int'(req), 1);
    take(); ret(); tick();
    chk("R5 no re-raise with pin low", int'(req), 0);

    // R7 block then deliver after return
    do_reset();
    wr(1'b0, 8'h89);
    ext_n[0] = 1'b0; tick(); tick();
    take();
    ext_n[0] = 1'b1;
    tmr_ovf[1] = 1'b1; tick(); tmr_ovf[1] = 1'b0; tick();
    chk("R7 timer held back in service", int'(req), 0);
    ret();
    chk("R7 delivered after return", int'(req), 1);
    chk("R7 delivered vector", int'(vec), 32'h1B);

    // R8 timer flag
    do_reset();
    wr(1'b0, 8'h82);
    tmr_ovf[0] = 1'b1; tick(); tmr_ovf[0] = 1'b0;
    chk("R8 timer 0 request", int'(req), 1);
    chk("R8 timer 0 vector", int'(vec), 32'h0B);
    take(); ret();
    chk("R8 flag cleared by acceptance", int'(req), 0);

    // R9 serial flags
    do_reset();
    wr(1'b0, 8'h90);
    tx_done = 1'b1; tick(); tx_done = 1'b0;
    chk("R9 transmit vector", int'(vec), 32'h23);
    take(); ret();
    chk("R9 survives acceptance", int'(req), 1);
    ser_clr = 2'b01; tick(); ser_clr = '0;
    chk("R9 transmit cleared by software", int'(req), 0);
    rx_done = 1'b1; tick(); rx_done = 1'b0;
    chk("R9 receive request", int'(req), 1);
    ser_clr = 2'b01; tick(); ser_clr = '0;
    chk("R9 transmit clear leaves receive", int'(req), 1);
    ser_clr = 2'b10; tick(); ser_clr = '0;
    chk("R9 receive cleared by software", int'(req), 0);

    // R10 mode bit positions
    do_reset();
    wr(1'b1, 8'hFA);
    wr(1'b0, 8'h81);
    ext_n[0] = 1'b0; tick(); tick();
    take(); ret();
    chk("R10 other mode bits keep external 0 level", int'(req), 1);
    do_reset();
    wr(1'b1, 8'h04);
    wr(1'b0, 8'h84);
    ext_n[1] = 1'b0; tick(); tick();
    chk("R10 external 1 vector", int'(vec), 32'h13);
    take(); ret(); tick();
    chk("R10 bit 2 makes external 1 edge", int'(req), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule